// File: doc/BRIEF.md
# SECDED Memory Datapath with Scrub Write-Back

This block sits between a host request port and a local word memory that stores 64 data bits plus an 8-bit check field per word. On every write that updates a whole word it computes check bits with an extended Hamming (72,64) code. The code uses seven Hamming bits plus one overall parity bit. On every read it recomputes the code and classifies the word as clean, single-bit faulty or multi-bit faulty. What happens next depends on a 2-bit integrity mode.

With checking on, a write that does not enable all eight bytes becomes a read, merge, re-encode and write sequence. When correction is also on, the read data is corrected first. In scrub mode a corrected single-bit fault found by a host read is written back to the same word in the same cycle, so a later second fault cannot combine with it into an uncorrectable one. Error events leave as one-cycle pulses together with the word address, for an external logger. The host is held off with a ready signal while a read or a read-modify-write is in flight.

Top module: `ecc_scrub_path`

## Requirements
- R1: A write with all eight byte enables set stores the data with freshly computed check bits. A later read returns the same data with no error pulse in modes 01, 10 and 11.
- R2: In mode 00 (no integrity), a write with any byte-enable pattern is done at once: ready stays high in the cycle after it, only the enabled bytes change and the check field is left untouched. err_sbe and err_mbe never pulse in this mode, and a read returns the raw stored data.
- R3: In mode 01 (check only), a read of a word with one flipped bit returns the raw, uncorrected data and pulses err_sbe.
- R4: In mode 01, a read of a word with two flipped bits returns the raw data and pulses err_mbe without err_sbe.
- R5: In mode 10 (correct), a single-bit fault is corrected in the returned data and err_sbe pulses. Memory is not rewritten, so a repeated read pulses err_sbe again.
- R6: In mode 10, a two-bit fault returns the raw data and pulses err_mbe without err_sbe.
- R7: In mode 11 (correct plus scrub), a single-bit fault is corrected and pulses err_sbe. The corrected word and its check bits are written back, so the next read of that word is clean.
- R8: In modes 01, 10 and 11, a write with some byte enables clear causes a read-modify-write: ready is low in the cycle after acceptance, and the enabled bytes (bit 8k+7..8k for enable k) replace the stored bytes. The check bits are recomputed over the merged word. In modes 10 and 11 a single-bit fault in the old word is corrected before the merge and err_sbe pulses.
- R9: A read-modify-write that finds a two-bit fault pulses err_mbe and leaves the stored word and check field unchanged.
- R10: A read accepted at edge E holds ready low for the next cycle and pulses rsp_valid for exactly one cycle after edge E+1. Any error pulse appears in that same cycle, with err_addr equal to the word address of the request. A read-modify-write reports its error pulse at the same point.
- R11: After reset, req_ready is high and rsp_valid, err_sbe and err_mbe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Integrity mode: 00 none, 01 check only, 10 correct, 11 correct and scrub |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Word address |
| req_be | input | 8 | Byte enables for writes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 64 | Read data |
| err_sbe | output | 1 | Single-bit error pulse |
| err_mbe | output | 1 | Multi-bit error pulse |
| err_addr | output | AW | Word address of the failing access |

## Verification
The assertions assume that mode does not change while the block is busy, that is while req_ready is low, and that request fields are stable while req_valid is high. The bench changes mode only between scenarios, while the block is idle. It raises req_valid for one accepted cycle per request. Faults are injected only through the ports: a mode-00 partial write flips bits in the data without updating the check field. The bench keeps each stored word known, so it can compute every expected word and flag.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DW = 64;
    localparam int HW = 7;
    localparam int CW = HW + 1;
    localparam int NB = DW / 8;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_RMW} fsm_e;

    // Codeword position (1-based) of data bit i; powers of two are skipped.
    function automatic logic [HW-1:0] bit_pos(input int i);
        int p;
        if (i < 1)       p = i + 3;
        else if (i < 4)  p = i + 4;
        else if (i < 11) p = i + 5;
        else if (i < 26) p = i + 6;
        else if (i < 57) p = i + 7;
        else             p = i + 8;
        return p[HW-1:0];
    endfunction

    // XOR of the positions of all set data bits.
    function automatic logic [HW-1:0] ham_bits(input logic [DW-1:0] d);
        logic [HW-1:0] h;
        h = '0;
        for (int i = 0; i < DW; i++) begin
            if (d[i]) h = h ^ bit_pos(i);
        end
        return h;
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ecc_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [CW-1:0] check
);
    logic [HW-1:0] ham;
    always_comb begin
        ham   = ham_bits(data);
        check = {(^data) ^ (^ham), ham};
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ecc_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] check,
    output logic [DW-1:0] corr,
    output logic          sbe,
    output logic          mbe
);
    logic [HW-1:0] syn;
    logic          par_err;
    logic          in_range;
    logic [DW-1:0] flip;

    always_comb begin
        syn      = ham_bits(data) ^ check[HW-1:0];
        par_err  = (^data) ^ (^check);
        in_range = (syn <= HW'(DW + HW));
    end

    for (genvar i = 0; i < DW; i++) begin : g_flip
        assign flip[i] = sbe && (syn == bit_pos(i));
    end

    assign sbe  = par_err && in_range;
    assign mbe  = (!par_err && (syn != '0)) || (par_err && !in_range);
    assign corr = data ^ flip;

    // A word is never both correctable and uncorrectable.
    always_comb begin
        assert (!(sbe && mbe) || $isunknown({data, check}));
    end
endmodule

// File: rtl/ecc_mem.sv
module ecc_mem
    import ecc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [NB-1:0] wr_be,
    input  logic          ck_we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] wcheck,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] rcheck
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [7:0] lane_q [DEPTH];
        logic [7:0] rd_q;
        always_ff @(posedge clk) begin
            if (wr_be[b]) lane_q[addr] <= wdata[b*8 +: 8];
            if (rd_en)    rd_q <= lane_q[addr];
        end
        assign rdata[b*8 +: 8] = rd_q;
    end

    logic [CW-1:0] ck_q [DEPTH];
    logic [CW-1:0] ck_rd_q;
    always_ff @(posedge clk) begin
        if (ck_we) ck_q[addr] <= wcheck;
        if (rd_en) ck_rd_q <= ck_q[addr];
    end
    assign rcheck = ck_rd_q;
endmodule

// File: rtl/ecc_scrub_path.sv
module ecc_scrub_path
    import ecc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [NB-1:0] req_be,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          err_sbe,
    output logic          err_mbe,
    output logic [AW-1:0] err_addr
);
    typedef struct packed {
        fsm_e          st;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
        logic [DW-1:0] wdata;
        logic          rsp_v;
        logic [DW-1:0] rsp_d;
        logic          sbe;
        logic          mbe;
        logic [AW-1:0] eaddr;
    } state_t;

    state_t q_q, n_d;

    logic          chk_on, fix_on, scrub_on;
    logic          m_re, m_ckwe;
    logic [NB-1:0] m_be;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wd, m_rd;
    logic [CW-1:0] m_rck, enc_ck;
    logic [DW-1:0] enc_in, base_d, merged_d, dec_corr;
    logic          dec_sbe, dec_mbe;

    assign chk_on   = (mode != 2'b00);
    assign fix_on   = mode[1];
    assign scrub_on = (mode == 2'b11);

    ecc_mem #(.AW(AW)) u_mem (
        .clk(clk), .rd_en(m_re), .wr_be(m_be), .ck_we(m_ckwe), .addr(m_addr),
        .wdata(m_wd), .wcheck(enc_ck), .rdata(m_rd), .rcheck(m_rck)
    );

    secded_dec u_dec (
        .data(m_rd), .check(m_rck), .corr(dec_corr), .sbe(dec_sbe), .mbe(dec_mbe)
    );

    secded_enc u_enc (.data(enc_in), .check(enc_ck));

    always_comb begin
        base_d = (fix_on && dec_sbe) ? dec_corr : m_rd;
        for (int b = 0; b < NB; b++) begin
            merged_d[b*8 +: 8] = q_q.be[b] ? q_q.wdata[b*8 +: 8] : base_d[b*8 +: 8];
        end
        case (q_q.st)
            ST_RD:   enc_in = dec_corr;
            ST_RMW:  enc_in = merged_d;
            default: enc_in = req_wdata;
        endcase
    end

    always_comb begin
        n_d       = q_q;
        n_d.rsp_v = 1'b0;
        n_d.sbe   = 1'b0;
        n_d.mbe   = 1'b0;
        m_re      = 1'b0;
        m_be      = '0;
        m_ckwe    = 1'b0;
        m_addr    = q_q.addr;
        m_wd      = enc_in;
        case (q_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    m_addr    = req_addr;
                    n_d.addr  = req_addr;
                    n_d.be    = req_be;
                    n_d.wdata = req_wdata;
                    if (!req_write) begin
                        m_re   = 1'b1;
                        n_d.st = ST_RD;
                    end else if ((&req_be) || !chk_on) begin
                        m_be   = req_be;
                        m_ckwe = &req_be;
                    end else begin
                        m_re   = 1'b1;
                        n_d.st = ST_RMW;
                    end
                end
            end
            ST_RD: begin
                n_d.st    = ST_IDLE;
                n_d.rsp_v = 1'b1;
                n_d.rsp_d = (fix_on && dec_sbe) ? dec_corr : m_rd;
                n_d.sbe   = chk_on && dec_sbe;
                n_d.mbe   = chk_on && dec_mbe;
                n_d.eaddr = q_q.addr;
                if (scrub_on && dec_sbe) begin
                    m_be   = '1;
                    m_ckwe = 1'b1;
                end
            end
            ST_RMW: begin
                n_d.st    = ST_IDLE;
                n_d.sbe   = chk_on && dec_sbe;
                n_d.mbe   = chk_on && dec_mbe;
                n_d.eaddr = q_q.addr;
                if (!dec_mbe) begin
                    m_be   = '1;
                    m_ckwe = 1'b1;
                end
            end
            default: n_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= n_d;
        end
    end

    assign req_ready = (q_q.st == ST_IDLE);
    assign rsp_valid = q_q.rsp_v;
    assign rsp_rdata = q_q.rsp_d;
    assign err_sbe   = q_q.sbe;
    assign err_mbe   = q_q.mbe;
    assign err_addr  = q_q.eaddr;

    // Input assumption: mode is held while a request is in flight.
    p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> $stable(mode));

    p_rd_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !req_ready);

    p_rd_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> ##1 rsp_valid);

    p_sbe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_sbe |=> !err_sbe);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_sbe && err_mbe));

    p_quiet_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && $stable(mode)) |-> !(err_sbe || err_mbe));

    p_direct_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && mode == 2'b00) |=> req_ready);

    p_rmw_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !(&req_be) && mode != 2'b00)
        |=> !req_ready);
endmodule

// File: tb/ecc_scrub_path_test.sv
`timescale 1ns/1ps
module ecc_scrub_path_test;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b10;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_be = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          err_sbe, err_mbe;
    logic [AW-1:0] err_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    ecc_scrub_path #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .err_sbe(err_sbe), .err_mbe(err_mbe),
        .err_addr(err_addr)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one write; returns ready one cycle later and error flags two cycles later.
    task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be,
                            output logic rdy1, output logic sbe, output logic mbe,
                            output logic [AW-1:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        rdy1 = req_ready;
        @(negedge clk);
        sbe = err_sbe; mbe = err_mbe; ea = err_addr;
        @(negedge clk);
    endtask

    // Drives one read and checks the handshake timing (R10).
    task automatic do_read(input logic [AW-1:0] a, output logic [63:0] d,
                           output logic sbe, output logic mbe, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R10 ready low"}, 64'(req_ready), 64'd0);
        @(negedge clk);
        check({req, " R10 rsp_valid"}, 64'(rsp_valid), 64'd1);
        d = rsp_rdata; sbe = err_sbe; mbe = err_mbe;
        if (sbe || mbe) check({req, " R10 err_addr"}, 64'(err_addr), 64'(a));
        @(negedge clk);
        check({req, " R10 pulse width"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic wr_full(input logic [AW-1:0] a, input logic [63:0] d);
        logic r, s, m; logic [AW-1:0] e;
        do_write(a, d, 8'hFF, r, s, m, e);
    endtask

    task automatic rd_expect(input logic [AW-1:0] a, input logic [63:0] exp,
                             input logic es, input logic em, input string req);
        logic [63:0] d; logic s, m;
        do_read(a, d, s, m, req);
        check({req, " data"}, d, exp);
        check({req, " sbe"}, 64'(s), 64'(es));
        check({req, " mbe"}, 64'(m), 64'(em));
    endtask

    localparam logic [63:0] D1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] D2 = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] D3 = 64'hA5A5_5A5A_0F0F_F0F0;
    localparam logic [63:0] D2X = D2 ^ (64'h11 << 16);

    task automatic t_reset;
        check("R11 ready", 64'(req_ready), 64'd1);
        check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 flags", 64'({err_sbe, err_mbe}), 64'd0);
    endtask

    task automatic t_clean;
        mode = 2'b10;
        wr_full(4'd0, 64'd0);
        wr_full(4'd15, '1);
        wr_full(4'd3, D1);
        wr_full(4'd5, D2);
        rd_expect(4'd0, 64'd0, 1'b0, 1'b0, "R1 zeros");
        rd_expect(4'd15, '1, 1'b0, 1'b0, "R1 ones");
        mode = 2'b01;
        rd_expect(4'd3, D1, 1'b0, 1'b0, "R1 mode01");
        mode = 2'b11;
        rd_expect(4'd5, D2, 1'b0, 1'b0, "R1 mode11");
    endtask

    task automatic t_none;
        logic r, s, m; logic [AW-1:0] e;
        mode = 2'b00;
        do_write(4'd3, 64'h00EE, 8'h01, r, s, m, e);
        check("R2 no stall", 64'(r), 64'd1);
        do_write(4'd5, 64'h0045_0000, 8'h04, r, s, m, e);
        check("R2 no flags on write", 64'({s, m}), 64'd0);
        rd_expect(4'd3, D1 ^ 64'h1, 1'b0, 1'b0, "R2 raw single");
        rd_expect(4'd5, D2X, 1'b0, 1'b0, "R2 raw double");
    endtask

    task automatic t_detect;
        mode = 2'b01;
        rd_expect(4'd3, D1 ^ 64'h1, 1'b1, 1'b0, "R3 detect single");
        rd_expect(4'd5, D2X, 1'b0, 1'b1, "R4 detect double");
    endtask

    task automatic t_correct;
        mode = 2'b10;
        rd_expect(4'd3, D1, 1'b1, 1'b0, "R5 correct");
        rd_expect(4'd3, D1, 1'b1, 1'b0, "R5 not scrubbed");
        rd_expect(4'd5, D2X, 1'b0, 1'b1, "R6 double");
    endtask

    task automatic t_scrub;
        mode = 2'b11;
        rd_expect(4'd3, D1, 1'b1, 1'b0, "R7 scrub first");
        rd_expect(4'd3, D1, 1'b0, 1'b0, "R7 scrub clean");
        mode = 2'b01;
        rd_expect(4'd3, D1, 1'b0, 1'b0, "R7 stored fixed");
    endtask

    task automatic t_rmw;
        logic r, s, m; logic [AW-1:0] e;
        mode = 2'b10;
        wr_full(4'd7, D3);
        do_write(4'd7, 64'h1122_3344_5566_7788, 8'hF0, r, s, m, e);
        check("R8 stall", 64'(r), 64'd0);
        check("R8 no flags", 64'({s, m}), 64'd0);
        rd_expect(4'd7, 64'h1122_3344_0F0F_F0F0, 1'b0, 1'b0, "R8 merged");
        mode = 2'b00;
        do_write(4'd7, 64'h0000_0000_0000_F400, 8'h02, r, s, m, e);
        mode = 2'b10;
        do_write(4'd7, 64'h3C, 8'h01, r, s, m, e);
        check("R8 sbe on rmw", 64'(s), 64'd1);
        check("R10 rmw err_addr", 64'(e), 64'd7);
        rd_expect(4'd7, 64'h1122_3344_0F0F_F03C, 1'b0, 1'b0, "R8 corrected merge");
    endtask

    task automatic t_rmw_mbe;
        logic r, s, m; logic [AW-1:0] e;
        mode = 2'b10;
        do_write(4'd5, 64'h99, 8'h01, r, s, m, e);
        check("R9 mbe on rmw", 64'({s, m}), 64'b01);
        mode = 2'b01;
        rd_expect(4'd5, D2X, 1'b0, 1'b1, "R9 unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_none();
        t_detect();
        t_correct();
        t_scrub();
        t_rmw();
        t_rmw_mbe();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule